// File: doc/BRIEF.md
# Microcoded Control Word Decoder

This block is the control store of a small accumulator machine with a 4-bit datapath. It is purely combinational. A 7-bit index is formed from the current 4-bit opcode, the carry flag, the equal flag and the phase bit. That index selects one 16-bit control word, whose bits drive the datapath directly: operand and memory bus enables, register load strobes, program counter control, port strobes and the ALU selects.

Branches are resolved inside the table itself. The two flags are index bits, so each jump opcode already holds the taken and not-taken words. No separate condition logic sits between the flags and the program counter. The table is also filled so that the active-low carry-in bit always copies opcode bit 3 and the ALU mode bit always copies opcode bit 2. This holds for every entry, including fetch entries and entries where those bits would not otherwise matter. A datapath may therefore wire those two controls straight from the opcode.

The opcode encoding used throughout is: 0 compare immediate, 1 compare memory, 2 load literal, 3 port write, 4 NOR immediate, 5 NOR memory, 6 jump, 7 jump if carry, 8 jump if equal, 9 jump if no carry, A add immediate, B add memory, C load memory, D store memory, E port read, F jump if not equal.

Top module: `ucode_decoder`

## Requirements
- R1: With phase_i=0, for every opcode and flag value, ctrl_o[15:6] = 10'h3EF and ctrl_o[3:0] = 4'h0. This means only the instruction-register load (bit 10, active low) is asserted and the PC increment (bit 11) is 1.
- R2: For all 128 index values, ctrl_o[5] (active-low carry-in) equals opcode_i[3] and ctrl_o[4] (ALU mode) equals opcode_i[2].
- R3: Add immediate (opcode 4'hA) in phase 1, for any flags, drives the following. Bit 15 (operand enable, low) = 0, bit 14 (accumulator load, low) = 0, bit 13 (flag load, low) = 0, bit 11 (PC increment) = 0, ctrl_o[3:0] = 4'b1001 (add), and carry-in bit 5 = 1 (no carry-in).
- R4: Jump if equal (opcode 4'h8) in phase 1 with equal_i=1 gives bit 12 (PC load, low) = 0 and bit 11 = 0. With equal_i=0 it gives bit 12 = 1 and bit 11 = 1. The carry flag has no effect on this word.
- R5: Jump (6) is always taken. Jump if carry (7) is taken when carry_i=1, jump if no carry (9) when carry_i=0, and jump if not equal (F) when equal_i=0. A taken jump gives bits 12/11 = 0/0 and a not-taken jump gives 1/1.
- R6: Every jump entry leaves bits 14, 13 and 9:6 at 1 and ctrl_o[3:0] at 0. Jumps load neither the accumulator nor the flags and drive no memory or port strobe.
- R7: Compare immediate (0) and compare memory (1) set bit 13 = 0, keep bit 14 = 1, and select subtract 4'b0110 with carry-in bit 5 = 0. The operand comes from bit 15 for compare immediate and from memory read bit 9 for compare memory.
- R8: NOR immediate (4) and NOR memory (5) set bits 14 and 13 to 0, select 4'b0001 and have mode bit 4 = 1.
- R9: In phase 1, the memory-operand opcodes (1, 5, B, C, D) set bit 11 = 1 to step past the address byte. Memory read is bit 9 low for all of them except store (D), which instead sets memory write bit 8 = 0. Add memory (B) loads the accumulator and the flags with select 4'b1001.
- R10: Load literal (2), port read (E) and load memory (C) set bit 14 = 0, bit 13 = 1 and select 4'b1010 (pass). Their sources are bit 15, bit 7 and bit 9 respectively.
- R11: Port write (3) sets only bit 6 = 0 among the strobes, with ctrl_o[3:0] = 0 and bit 11 = 0.
- R12: Every phase-1 entry keeps bit 10 at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 4 | Current instruction opcode |
| carry_i | input | 1 | Carry flag from the ALU |
| equal_i | input | 1 | Equal flag from the ALU |
| phase_i | input | 1 | 0 for fetch, 1 for execute |
| ctrl_o | output | 16 | Control word to the datapath |

## Verification
The full 128-entry index space is applied in three orders: an ascending sweep, a descending sweep and a stride-37 walk. The ascending sweep toggles the phase bit between neighbouring entries, so it separates fetch words from execute words. The descending sweep reaches each jump with the flags changing in the opposite direction, which exposes a taken/not-taken pair tied to the wrong flag or wrongly inverted. The strided walk changes opcode bits and flag bits together, so it catches index bits that are swapped or wired to the wrong position. At every step the whole word is compared with a reference model written by opcode name, and the two opcode-mirrored bits are checked on their own.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int OPC_W = 4;
  localparam int CW_W  = 16;
  localparam int IDX_W = OPC_W + 3;

  localparam logic [3:0] FN_NONE = 4'b0000;
  localparam logic [3:0] FN_NOR  = 4'b0001;
  localparam logic [3:0] FN_SUB  = 4'b0110;
  localparam logic [3:0] FN_ADD  = 4'b1001;
  localparam logic [3:0] FN_PASS = 4'b1010;

  typedef enum logic [OPC_W-1:0] {
    OP_CMPI = 4'h0, OP_CMPM = 4'h1, OP_LIT  = 4'h2, OP_PWR  = 4'h3,
    OP_NORI = 4'h4, OP_NORM = 4'h5, OP_JMP  = 4'h6, OP_JC   = 4'h7,
    OP_JE   = 4'h8, OP_JNC  = 4'h9, OP_ADDI = 4'hA, OP_ADDM = 4'hB,
    OP_LDM  = 4'hC, OP_STM  = 4'hD, OP_PRD  = 4'hE, OP_JNE  = 4'hF
  } opc_e;

  typedef struct packed {
    logic       oe_imm_n;
    logic       ld_acc_n;
    logic       ld_flg_n;
    logic       ld_pc_n;
    logic       pc_inc;
    logic       ld_ir_n;
    logic       mem_rd_n;
    logic       mem_wr_n;
    logic       port_rd_n;
    logic       port_wr_n;
    logic       cin_n;
    logic       alu_m;
    logic [3:0] alu_fn;
  } ctl_t;

  // index layout: {opcode, carry, equal, phase}
  function automatic ctl_t ctl_entry(logic [IDX_W-1:0] idx);
    ctl_t w;
    opc_e op;
    logic c, e, take;
    op   = opc_e'(idx[IDX_W-1:3]);
    c    = idx[2];
    e    = idx[1];
    w    = '{oe_imm_n: 1'b1, ld_acc_n: 1'b1, ld_flg_n: 1'b1, ld_pc_n: 1'b1,
             pc_inc: 1'b0, ld_ir_n: 1'b1, mem_rd_n: 1'b1, mem_wr_n: 1'b1,
             port_rd_n: 1'b1, port_wr_n: 1'b1, cin_n: 1'b0, alu_m: 1'b0,
             alu_fn: FN_NONE};
    case (op)
      OP_JMP:  take = 1'b1;
      OP_JC:   take = c;
      OP_JNC:  take = !c;
      OP_JE:   take = e;
      OP_JNE:  take = !e;
      default: take = 1'b0;
    endcase
    if (!idx[0]) begin
      w.ld_ir_n = 1'b0;
      w.pc_inc  = 1'b1;
    end else begin
      case (op)
        OP_CMPI: begin w.oe_imm_n = 1'b0; w.ld_flg_n = 1'b0; w.alu_fn = FN_SUB; end
        OP_CMPM: begin w.mem_rd_n = 1'b0; w.ld_flg_n = 1'b0; w.alu_fn = FN_SUB; w.pc_inc = 1'b1; end
        OP_LIT:  begin w.oe_imm_n = 1'b0; w.ld_acc_n = 1'b0; w.alu_fn = FN_PASS; end
        OP_PWR:  w.port_wr_n = 1'b0;
        OP_NORI: begin w.oe_imm_n = 1'b0; w.ld_acc_n = 1'b0; w.ld_flg_n = 1'b0; w.alu_fn = FN_NOR; end
        OP_NORM: begin
          w.mem_rd_n = 1'b0; w.ld_acc_n = 1'b0; w.ld_flg_n = 1'b0;
          w.alu_fn = FN_NOR; w.pc_inc = 1'b1;
        end
        OP_ADDI: begin w.oe_imm_n = 1'b0; w.ld_acc_n = 1'b0; w.ld_flg_n = 1'b0; w.alu_fn = FN_ADD; end
        OP_ADDM: begin
          w.mem_rd_n = 1'b0; w.ld_acc_n = 1'b0; w.ld_flg_n = 1'b0;
          w.alu_fn = FN_ADD; w.pc_inc = 1'b1;
        end
        OP_LDM:  begin w.mem_rd_n = 1'b0; w.ld_acc_n = 1'b0; w.alu_fn = FN_PASS; w.pc_inc = 1'b1; end
        OP_STM:  begin w.mem_wr_n = 1'b0; w.pc_inc = 1'b1; end
        OP_PRD:  begin w.port_rd_n = 1'b0; w.ld_acc_n = 1'b0; w.alu_fn = FN_PASS; end
        default: begin w.ld_pc_n = !take; w.pc_inc = !take; end
      endcase
    end
    // don't-care bits pinned to opcode bits so the datapath may bypass them
    w.cin_n = idx[IDX_W-1];
    w.alu_m = idx[IDX_W-2];
    return w;
  endfunction
endpackage

// File: rtl/ucode_index.sv
module ucode_index #(
  parameter int OPC_W = 4,
  localparam int IDX_W = OPC_W + 3
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             carry_i,
  input  logic             equal_i,
  input  logic             phase_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = {opcode_i, carry_i, equal_i, phase_i};
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom #(
  parameter int IDX_W = 7,
  parameter int CW_W  = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CW_W-1:0]  word_o
);
  logic [CW_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = CW_W'(ucode_pkg::ctl_entry(ucode_pkg::IDX_W'(g)));
  end

  assign word_o = rom[idx_i];
endmodule

// File: rtl/ucode_decoder.sv
module ucode_decoder #(
  parameter int OPC_W = ucode_pkg::OPC_W,
  parameter int CW_W  = ucode_pkg::CW_W,
  localparam int IDX_W = OPC_W + 3
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             carry_i,
  input  logic             equal_i,
  input  logic             phase_i,
  output logic [CW_W-1:0]  ctrl_o
);
  logic [IDX_W-1:0] idx;

  ucode_index #(.OPC_W(OPC_W)) u_index (
    .opcode_i(opcode_i),
    .carry_i (carry_i),
    .equal_i (equal_i),
    .phase_i (phase_i),
    .idx_o   (idx)
  );

  ucode_rom #(.IDX_W(IDX_W), .CW_W(CW_W)) u_rom (
    .idx_i (idx),
    .word_o(ctrl_o)
  );
endmodule

// File: rtl/ucode_decoder_chk.sv
module ucode_decoder_chk (
  input logic [3:0]  opcode_i,
  input logic        carry_i,
  input logic        equal_i,
  input logic        phase_i,
  input logic [15:0] ctrl_o
);
  logic is_jump;
  assign is_jump = opcode_i inside {4'h6, 4'h7, 4'h8, 4'h9, 4'hF};

  always_comb begin
    AST_CIN_MIRROR: assert (ctrl_o[5] == opcode_i[3]) else $error("cin mirror"); // R2
    AST_MODE_MIRROR: assert (ctrl_o[4] == opcode_i[2]) else $error("mode mirror"); // R2
    if (!phase_i) begin
      AST_FETCH_WORD: assert (ctrl_o[15:6] == 10'h3EF && ctrl_o[3:0] == 4'h0) else $error("fetch word"); // R1
    end else begin
      AST_NO_FETCH_EXEC: assert (ctrl_o[10]) else $error("fetch in exec"); // R12
    end
    AST_PC_EXCL: assert (ctrl_o[12] || !ctrl_o[11]) else $error("pc load and inc"); // R4
    if (phase_i && opcode_i == 4'hA) begin
      AST_ADDI_WORD: assert (ctrl_o[15:13] == 3'b000 && ctrl_o[3:0] == 4'b1001) else $error("addi"); // R3
    end
    if (phase_i && opcode_i == 4'h8) begin
      AST_JE_FLAG: assert (ctrl_o[12] == !equal_i && ctrl_o[11] == !equal_i) else $error("je"); // R4
    end
    if (phase_i && opcode_i == 4'h7) begin
      AST_JC_FLAG: assert (ctrl_o[12] == !carry_i) else $error("jc"); // R5
    end
    if (phase_i && is_jump) begin
      AST_JUMP_QUIET: assert (ctrl_o[14:13] == 2'b11 && ctrl_o[9:6] == 4'hF) else $error("jump quiet"); // R6
    end
  end
endmodule

bind ucode_decoder ucode_decoder_chk u_chk (
  .opcode_i(opcode_i),
  .carry_i (carry_i),
  .equal_i (equal_i),
  .phase_i (phase_i),
  .ctrl_o  (ctrl_o)
);

// File: tb/sim_ucode_decoder.sv
`timescale 1ns/1ps
module sim_ucode_decoder;
  logic       clk = 1'b0;
  logic [3:0] opcode;
  logic       carry, equal, phase;
  logic [15:0] ctrl;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  ucode_decoder u0 (
    .opcode_i(opcode),
    .carry_i (carry),
    .equal_i (equal),
    .phase_i (phase),
    .ctrl_o  (ctrl)
  );

  function automatic logic [15:0] exp_word(int op, int c, int e, int ph);
    bit oe_imm = 1, ld_a = 1, ld_f = 1, ld_pc = 1, inc = 0, ld_ir = 1;
    bit mrd = 1, mwr = 1, prd = 1, pwr = 1, take;
    bit [3:0] fn = 0;
    if (ph == 0) begin
      ld_ir = 0; inc = 1;  // R1
    end else begin
      if (op inside {1, 5, 11, 12, 13}) inc = 1;  // R9
      case (op)
        0:  begin oe_imm = 0; ld_f = 0; fn = 4'b0110; end          // R7
        1:  begin mrd = 0; ld_f = 0; fn = 4'b0110; end             // R7
        2:  begin oe_imm = 0; ld_a = 0; fn = 4'b1010; end          // R10
        3:  pwr = 0;                                               // R11
        4:  begin oe_imm = 0; ld_a = 0; ld_f = 0; fn = 4'b0001; end // R8
        5:  begin mrd = 0; ld_a = 0; ld_f = 0; fn = 4'b0001; end    // R8
        10: begin oe_imm = 0; ld_a = 0; ld_f = 0; fn = 4'b1001; end // R3
        11: begin mrd = 0; ld_a = 0; ld_f = 0; fn = 4'b1001; end    // R9
        12: begin mrd = 0; ld_a = 0; fn = 4'b1010; end             // R10
        13: mwr = 0;                                               // R9
        14: begin prd = 0; ld_a = 0; fn = 4'b1010; end             // R10
        default: begin                                             // R4 R5 R6
          take = (op == 6) || (op == 7 && c == 1) || (op == 9 && c == 0) ||
                 (op == 8 && e == 1) || (op == 15 && e == 0);
          ld_pc = !take; inc = !take;
        end
      endcase
    end
    return {oe_imm, ld_a, ld_f, ld_pc, inc, ld_ir, mrd, mwr, prd, pwr,
            bit'((op >> 3) & 1), bit'((op >> 2) & 1), fn};
  endfunction

  function automatic string req_of(int op, int ph);
    if (ph == 0) return "R1";
    case (op)
      0, 1:        return "R7 R12";
      2, 12, 14:   return "R10 R12";
      3:           return "R11 R12";
      4, 5:        return "R8 R12";
      10:          return "R3 R12";
      11, 13:      return "R9 R12";
      8:           return "R4 R6 R12";
      default:     return "R5 R6 R12";
    endcase
  endfunction

  task automatic apply(int a);
    logic [15:0] exp;
    @(negedge clk);
    {opcode, carry, equal, phase} = 7'(a);
    @(posedge clk);
    #2;
    exp = exp_word(a >> 3, (a >> 2) & 1, (a >> 1) & 1, a & 1);
    tests++;
    if (ctrl !== exp) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", req_of(a >> 3, a & 1), a, ctrl, exp);
    end
    tests++;  // R2 mirror bits
    if (ctrl[5] !== opcode[3] || ctrl[4] !== opcode[2]) begin
      fails++;
      $display("FAIL R2 idx=%0d actual=%b%b expected=%b%b", a, ctrl[5], ctrl[4], opcode[3], opcode[2]);
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    {opcode, carry, equal, phase} = 7'd0;
    @(posedge clk);
    #2;
    tests++;  // R1 idle inputs
    if (ctrl !== 16'hFBC0) begin
      fails++;
      $display("FAIL R1 start actual=%h expected=%h", ctrl, 16'hFBC0);
    end
    for (int a = 0; a < 128; a++) apply(a);
    for (int a = 127; a >= 0; a--) apply(a);
    for (int k = 0; k < 128; k++) apply((k * 37 + 5) % 128);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule